// File: doc/BRIEF.md
# Vectored Interrupt Handshake Controller

This block is the controller half of a vectored interrupt exchange with a processor. A set of request lines, each given a programmable priority, is arbitrated every cycle. When a request outranks every level already being serviced, the block pulls an active-low interrupt line. The processor answers by raising an acknowledge. The block then places the winning source's vector on an address bus and raises a valid strobe. When the processor drops its acknowledge, the block records the serviced priority and lowers the strobe.

Serviced priorities are kept on an in-service stack. Only requests strictly more urgent than the top of the stack can interrupt. Software pops the stack with a completion write once a handler finishes. Request lines are never cleared by the block: each source withdraws its own request. The acknowledge input passes through a two-flop synchroniser when the processor clock is unrelated, or through a single register when both sides share a clock.

Top module: `vic_port`

## Requirements
- R1: With no serviced level stacked, the interrupt output is low one clock edge after any request is high, and high one edge after all requests are low. With a level T on top of the stack, only requests whose priority value is numerically below T count.
- R2: A smaller priority value is more urgent. On a tie, the lowest-numbered source wins. While the valid strobe is low, the vector bus follows the winner's vector, registered one edge behind the requests.
- R3: When the acknowledge is seen high while the interrupt output is low, the valid strobe rises. In synchronous mode this happens on the third clock edge after the acknowledge input goes high. The winner on that edge supplies the vector.
- R4: While the valid strobe is high, the vector bus does not change, even if a more urgent request arrives.
- R5: When the acknowledge is seen low, the serviced priority is pushed onto the stack, and the valid strobe falls on the third edge after the acknowledge input goes low. The interrupt output takes its new value on that same edge, and it is held during the strobe so it never changes before the strobe falls.
- R6: A write to the completion region pops the top of the stack. This re-enables the levels it masked, and the interrupt output responds one edge after the pop edge.
- R7: A completion write while the stack is empty has no effect. A later push and the masking it causes behave as if the write never happened.
- R8: Writes use a 6-bit address whose top two bits pick a region: 00 is a source's 32-bit vector, 01 is its 4-bit priority, and 10 is completion. The low four bits pick the source. After reset, vectors are 0 and priorities are 15.
- R9: A request still held after its own service stays masked and is not cleared. In asynchronous mode the acknowledge passes through two flops, so the valid strobe rises one edge later than in synchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 16 | Interrupt request lines, one per source |
| ack | input | 1 | Acknowledge from the processor |
| irq_n | output | 1 | Active-low interrupt request to the processor |
| vec_addr | output | 32 | Vector address of the selected source |
| vec_valid | output | 1 | Vector address is stable and valid |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address (region and source) |
| wr_data | input | 32 | Register write data |

## Verification
A request change shows on the interrupt output and on the vector bus one edge later. A completion write shows on the interrupt output one edge after the pop edge. In synchronous mode, the valid strobe rises three edges after the acknowledge goes high, and falls together with the interrupt update three edges after it goes low. The asynchronous instance adds one edge. The bench drives inputs just after a falling edge, steps a known number of rising edges, and samples at the next falling edge. It checks the strobe just before and exactly on its due edge, so an off-by-one shift is reported.

// File: rtl/vic_pkg.sv
// Shared types and constants for the vectored interrupt handshake port.
package vic_pkg;

    // Handshake sequencer states
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,  // waiting for acknowledge, vector tracks winner
        HS_ARM  = 2'd1,  // acknowledge seen, last re-selection of vector
        HS_HOLD = 2'd2,  // strobe high, vector frozen
        HS_FIN  = 2'd3   // priority stacked, strobe and irq update together
    } hs_state_t;

    // Register port regions (top two address bits)
    localparam logic [1:0] REG_VEC  = 2'b00;
    localparam logic [1:0] REG_PRI  = 2'b01;
    localparam logic [1:0] REG_DONE = 2'b10;

endpackage

// File: rtl/vic_ack_sync.sv
// Acknowledge input conditioner.
// Assumes: ASYNC=1 when the processor clock is unrelated to clk (two flops),
// ASYNC=0 when both share a clock (one register, one cycle of delay).
module vic_ack_sync #(
    parameter bit ASYNC = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_in,
    output logic ack_s
);

    generate
        if (ASYNC) begin : g_two_stage
            logic meta;
            // Two-stage synchroniser against metastability
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta  <= 1'b0;
                    ack_s <= 1'b0;
                end else begin
                    meta  <= ack_in;
                    ack_s <= meta;
                end
            end
        end else begin : g_one_stage
            // Single register for the synchronous case
            always_ff @(posedge clk) begin
                if (!rst_n) ack_s <= 1'b0;
                else        ack_s <= ack_in;
            end
        end
    endgenerate

endmodule

// File: rtl/vic_arbiter.sv
// Combinational priority arbiter.
// Picks the pending source with the smallest priority value that is
// strictly below the mask limit; ties go to the lowest source index.
// Assumes: limit = 2**PW means no masking.
module vic_arbiter #(
    parameter int NSRC = 16,
    parameter int PW   = 4,
    parameter int SW   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] req,
    input  logic [PW-1:0]   pri [NSRC],
    input  logic [PW:0]     limit,
    output logic            hit,
    output logic [SW-1:0]   win_idx,
    output logic [PW-1:0]   win_pri
);

    // Linear scan, ascending index so a strict compare keeps the lower index
    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        win_pri = '1;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && ({1'b0, pri[i]} < limit) && (!hit || (pri[i] < win_pri))) begin
                hit     = 1'b1;
                win_idx = SW'(i);
                win_pri = pri[i];
            end
        end
    end

endmodule

// File: rtl/vic_prio_stack.sv
// In-service priority stack.
// Push records a serviced level, pop (completion) removes the top.
// Pop on empty is ignored; push when full is ignored.
// top reports 2**PW when empty so that nothing is masked.
module vic_prio_stack #(
    parameter int PW    = 4,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [PW-1:0] push_pri,
    output logic [PW:0]   top,
    output logic          empty,
    output logic          full
);

    localparam int PTRW = $clog2(DEPTH + 1);
    localparam int IDXW = $clog2(DEPTH);

    logic [PW-1:0]   mem [DEPTH];
    logic [PTRW-1:0] sp;
    logic            do_push, do_pop;
    logic [IDXW-1:0] idx_top, idx_free;

    assign empty    = (sp == '0);
    assign full     = (sp == PTRW'(DEPTH));
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign idx_top  = IDXW'(sp - 1'b1);
    assign idx_free = IDXW'(sp);
    assign top      = empty ? (PW+1)'(1 << PW) : {1'b0, mem[idx_top]};

    // Stack pointer bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (do_push && !do_pop) begin
            sp <= sp + 1'b1;
        end else if (do_pop && !do_push) begin
            sp <= sp - 1'b1;
        end
    end

    // Entry storage; simultaneous push and pop replaces the top entry
    always_ff @(posedge clk) begin
        if (do_push && do_pop)  mem[idx_top]  <= push_pri;
        else if (do_push)       mem[idx_free] <= push_pri;
    end

    // A push never arrives on a full stack: each push outranks the top
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // Completion on an empty stack leaves it empty
    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> empty);

endmodule

// File: rtl/vic_port.sv
// Vectored interrupt handshake port (controller side).
// Arbitrates prioritised requests, drives an active-low interrupt, a vector
// bus and a valid strobe, and stacks serviced priorities until software
// signals completion. Assumes the processor only raises ack while irq_n is
// low and holds ack high until it has seen vec_valid high.
module vic_port #(
    parameter int NSRC  = 16,
    parameter int PW    = 4,
    parameter int VW    = 32,
    parameter int DEPTH = 16,
    parameter bit ASYNC = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           req,
    input  logic                      ack,
    output logic                      irq_n,
    output logic [VW-1:0]             vec_addr,
    output logic                      vec_valid,
    input  logic                      wr_en,
    input  logic [$clog2(NSRC)+1:0]   wr_addr,
    input  logic [VW-1:0]             wr_data
);

    import vic_pkg::*;

    localparam int SW = $clog2(NSRC);
    localparam int AW = SW + 2;

    logic [VW-1:0] vec_tab [NSRC];
    logic [PW-1:0] pri_tab [NSRC];
    logic [1:0]    region;
    logic [SW-1:0] slot;
    logic          done_wr;

    logic          ack_s;
    logic          hit;
    logic [SW-1:0] win_idx;
    logic [PW-1:0] win_pri;
    logic [PW:0]   limit;
    logic          stk_empty, stk_full;

    hs_state_t     state;
    logic [PW-1:0] svc_pri;
    logic          svc_ok;
    logic          push;
    logic          irq_q;
    logic [VW-1:0] vec_q;
    logic          valid_q;

    assign region  = wr_addr[AW-1:SW];
    assign slot    = wr_addr[SW-1:0];
    assign done_wr = wr_en && (region == REG_DONE);

    // Per-source vector and priority registers
    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            // Load this source's entries from the write port
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vec_tab[g] <= '0;
                    pri_tab[g] <= '1;
                end else if (wr_en && (slot == SW'(g))) begin
                    if (region == REG_VEC) vec_tab[g] <= wr_data;
                    if (region == REG_PRI) pri_tab[g] <= wr_data[PW-1:0];
                end
            end
        end
    endgenerate

    vic_ack_sync #(.ASYNC(ASYNC)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_in (ack),
        .ack_s  (ack_s)
    );

    vic_arbiter #(.NSRC(NSRC), .PW(PW), .SW(SW)) i_arb (
        .req     (req),
        .pri     (pri_tab),
        .limit   (limit),
        .hit     (hit),
        .win_idx (win_idx),
        .win_pri (win_pri)
    );

    vic_prio_stack #(.PW(PW), .DEPTH(DEPTH)) i_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (done_wr),
        .push_pri (svc_pri),
        .top      (limit),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    assign push = (state == HS_HOLD) && !ack_s && svc_ok;

    // Handshake sequencer: arm, raise strobe, stack on release, then settle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= HS_IDLE;
            valid_q <= 1'b0;
            svc_pri <= '0;
            svc_ok  <= 1'b0;
        end else begin
            case (state)
                HS_IDLE: if (ack_s && !irq_q) state <= HS_ARM;
                HS_ARM: begin
                    svc_pri <= win_pri;
                    svc_ok  <= hit;
                    valid_q <= 1'b1;
                    state   <= HS_HOLD;
                end
                HS_HOLD: if (!ack_s) state <= HS_FIN;
                HS_FIN: begin
                    valid_q <= 1'b0;
                    state   <= HS_IDLE;
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    // Vector tracks the winner until the strobe rises, then is frozen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if ((state == HS_IDLE || state == HS_ARM) && hit) begin
            vec_q <= vec_tab[win_idx];
        end
    end

    // Interrupt line follows the arbiter except while the strobe is pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b1;
        end else if (state != HS_ARM && state != HS_HOLD) begin
            irq_q <= !hit;
        end
    end

    assign irq_n     = irq_q;
    assign vec_addr  = vec_q;
    assign vec_valid = valid_q;

    // Vector bus is frozen while the strobe stays high
    assert_vec_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(vec_valid)) |-> $stable(vec_addr));

    // Strobe only rises after an acknowledge was seen
    assert_valid_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(ack_s));

    // Strobe only falls after the acknowledge was seen low
    assert_valid_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vec_valid) |-> !$past(ack_s));

    // Interrupt line never deasserts while the strobe is still high
    assert_irq_settled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> !vec_valid);

endmodule

// File: tb/test_vic_port.sv
`timescale 1ns/1ps
module test_vic_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic        ack = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;

    logic        irq_n, vec_valid;
    logic [31:0] vec_addr;
    logic        a_irq_n, a_vec_valid;
    logic [31:0] a_vec_addr;

    int n_chk = 0;
    int n_bad = 0;
    int pr [16];

    always #4 clk = ~clk;  // 125 MHz

    vic_port #(.ASYNC(1'b0)) i_vic_port (
        .clk(clk), .rst_n(rst_n), .req(req), .ack(ack),
        .irq_n(irq_n), .vec_addr(vec_addr), .vec_valid(vec_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    vic_port #(.ASYNC(1'b1)) i_vic_port_async (
        .clk(clk), .rst_n(rst_n), .req(req), .ack(ack),
        .irq_n(a_irq_n), .vec_addr(a_vec_addr), .vec_valid(a_vec_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

    function automatic logic [31:0] vf(input int s);
        return 32'h8000_0000 | (s << 8) | (s * 3);
    endfunction

    // Winner with priority strictly below lim, lowest index on tie; -1 if none
    function automatic int pick(input logic [15:0] p, input int lim);
        int w = -1;
        int bp = 99;
        for (int i = 0; i < 16; i++)
            if (p[i] && pr[i] < lim && pr[i] < bp) begin w = i; bp = pr[i]; end
        return w;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    // Plain handshake: valid due on third edge up, drops on third edge down
    task automatic handshake(input int src, input logic exp_irq_after);
        ack = 1'b1;
        step(); step();
        chk("R3 strobe low before due edge", 32'(vec_valid), 0);
        step();
        chk("R3 strobe high on due edge", 32'(vec_valid), 1);
        chk("R2 vector of served source", vec_addr, vf(src));
        ack = 1'b0;
        step(); step();
        chk("R5 strobe still high before release edge", 32'(vec_valid), 1);
        step();
        chk("R5 strobe low after release", 32'(vec_valid), 0);
        chk("R5 irq settled with strobe drop", 32'(irq_n), 32'(exp_irq_after));
    endtask

    task automatic sweep(input int count, input int seed);
        logic [15:0] pat;
        logic [31:0] ev;
        int w;
        pat = 16'(seed);
        ev = vec_addr;
        for (int k = 0; k < count; k++) begin
            pat = 16'(pat * 25173 + 13849);
            req = pat;
            step();
            w = pick(pat, 16);
            if (w >= 0) ev = vf(w);
            chk("R1 irq vs pending", 32'(irq_n), (w < 0) ? 1 : 0);
            chk("R2 vector of winner", vec_addr, ev);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        step();
        // R8: reset state
        chk("R8 reset irq_n", 32'(irq_n), 1);
        chk("R8 reset strobe", 32'(vec_valid), 0);
        chk("R8 reset vector", vec_addr, 0);

        // R8: program vectors and a priority permutation
        for (int s = 0; s < 16; s++) begin
            pr[s] = (s * 7 + 3) % 16;
            wr({2'b00, 4'(s)}, vf(s));
            wr({2'b01, 4'(s)}, 32'(pr[s]));
        end

        // R1 R2 R8: each source alone
        for (int s = 0; s < 16; s++) begin
            req = 16'(1 << s);
            step();
            chk("R1 single source irq", 32'(irq_n), 0);
            chk("R8 single source vector", vec_addr, vf(s));
        end
        req = '0;
        step();
        chk("R1 no requests", 32'(irq_n), 1);

        // R1 R2: pattern sweep with distinct priorities
        sweep(96, 7);

        // R2 R8: all priorities tied, lowest index must win
        for (int s = 0; s < 16; s++) begin
            pr[s] = 5;
            wr({2'b01, 4'(s)}, 32'd5);
        end
        sweep(48, 99);
        for (int s = 0; s < 16; s++) begin
            pr[s] = (s * 7 + 3) % 16;
            wr({2'b01, 4'(s)}, 32'(pr[s]));
        end

        // First handshake with re-selection during arming (s1 prio 10 -> s0 prio 3)
        req = 16'h0002;
        step();
        chk("R1 s1 raises irq", 32'(irq_n), 0);
        chk("R2 vector s1", vec_addr, vf(1));
        ack = 1'b1;
        step(); step();
        chk("R3 strobe low before due edge", 32'(vec_valid), 0);
        req = 16'h0003;
        step();
        chk("R3 strobe rises on third edge", 32'(vec_valid), 1);
        chk("R2 re-selected during arming", vec_addr, vf(0));
        chk("R9 async strobe one edge later", 32'(a_vec_valid), 0);
        req = 16'h0803;  // s11 prio 0 arrives while strobe high
        step();
        chk("R9 async strobe rises", 32'(a_vec_valid), 1);
        chk("R4 vector frozen", vec_addr, vf(0));
        step(); step();
        chk("R4 vector still frozen", vec_addr, vf(0));
        chk("R5 irq held during strobe", 32'(irq_n), 0);
        ack = 1'b0;
        step(); step();
        chk("R5 strobe high before release edge", 32'(vec_valid), 1);
        step();
        chk("R5 strobe low after release", 32'(vec_valid), 0);
        chk("R5 irq kept for more urgent s11", 32'(irq_n), 0);

        // Serve s11 (prio 0); everything left is masked, requests persist
        handshake(11, 1'b1);
        step(); step();
        chk("R9 held requests stay masked", 32'(irq_n), 1);

        // R6: pop level 0 -> s11 (prio 0 < 3) asserts again
        wr({2'b10, 4'd0}, 32'd0);
        chk("R6 irq one edge after pop", 32'(irq_n), 1);
        step();
        chk("R6 pop re-enables s11", 32'(irq_n), 0);
        req = 16'h0003;
        step();
        chk("R6 equal level masked", 32'(irq_n), 1);
        wr({2'b10, 4'd0}, 32'd0);
        step();
        chk("R6 empty stack unmasks all", 32'(irq_n), 0);
        chk("R6 vector after unmask", vec_addr, vf(0));

        // R7: completion on empty stack, then a push must mask normally
        req = '0;
        step();
        wr({2'b10, 4'd0}, 32'd0);
        step();
        chk("R7 no effect on idle irq", 32'(irq_n), 1);
        req = 16'h0010;  // s4 prio 15
        step();
        chk("R7 lowest level still unmasked", 32'(irq_n), 0);
        handshake(4, 1'b1);
        req = 16'h0012;  // add s1 prio 10
        step();
        chk("R7 single level stacked after empty pop", 32'(irq_n), 0);
        chk("R7 vector of s1", vec_addr, vf(1));

        summary();
        $finish;
    end

endmodule